// File: doc/BRIEF.md
# Multimode Bidirectional Bus Transceiver

This block carries data between two parallel ports, A and B, with one independent path per direction. Each path owns a single storage element per bit. Three controls set how that element behaves. With the latch enable high, the path is transparent. With the latch enable low and the active-low clock enable high, the path holds its value. With both low, the path stores a new word on a rising edge of its own direction clock. An active-low output enable per direction turns the driven side on or off. Pins are modelled as separate input, output and output-enable vectors; the enable vectors show which bits would be driven on a real bus.

The block runs on one system clock. The direction clocks are sampled on that clock, and a rising edge counts when a direction clock is seen high at one system edge after being seen low at the edge before. A test-mode input lets an external controller take over. While it is asserted, both output vectors carry controller-supplied words, every bit is enabled, and neither storage element changes. A synchronous reset clears both storage elements to zero.

Top module: `xcvr_bidir`

## Requirements
- R1: With test mode low and a direction's latch enable high, that direction's output equals its input in the same cycle, for every input word. The latch enable takes priority over the clocked path.
- R2: When the latch enable goes from high to low, the output keeps the input word sampled at the last system clock edge with the latch enable high.
- R3: With the latch enable low and the active-low clock enable high, the output keeps its stored word whatever the direction clock and input do.
- R4: With the latch enable and the clock enable both low, the input is stored at the system edge where the direction clock is sampled high after being sampled low. It appears on the output from that edge on.
- R5: A direction clock that stays high, stays low or falls stores nothing.
- R6: With test mode low, the output-enable vector is all ones when the active-low output enable is low, and all zeros when it is high.
- R7: The B-to-A path behaves exactly like the A-to-B path, using its own output enable, latch enable, clock enable and clock.
- R8: With test mode high, aOut equals testDriveA, bOut equals testDriveB, and both enable vectors are all ones. Neither storage element is updated, so the stored words are unchanged once test mode is released.
- R9: A synchronous reset clears both storage elements to zero. With the latch enable low, the outputs read zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | W | Word arriving at port A |
| bIn | input | W | Word arriving at port B |
| oeAbN | input | 1 | Drive enable for the B side, active low |
| leAb | input | 1 | A-to-B latch enable (transparent when high) |
| clkEnAbN | input | 1 | A-to-B clock enable, active low |
| clkAb | input | 1 | A-to-B direction clock, sampled on clk |
| oeBaN | input | 1 | Drive enable for the A side, active low |
| leBa | input | 1 | B-to-A latch enable |
| clkEnBaN | input | 1 | B-to-A clock enable, active low |
| clkBa | input | 1 | B-to-A direction clock, sampled on clk |
| testMode | input | 1 | Test override of both paths |
| testDriveA | input | W | Word driven on the A side in test mode |
| testDriveB | input | W | Word driven on the B side in test mode |
| bOut | output | W | Word presented on the B side |
| bOe | output | W | Per-bit drive enable for the B side |
| aOut | output | W | Word presented on the A side |
| aOe | output | W | Per-bit drive enable for the A side |

## Verification
The bench builds the block with W = 4, which is narrow enough to sweep all sixteen input words through the transparent path in both directions. The same width makes it cheap to push several distinct words through the edge-capture path. Each sweep is followed by falling, static-high and static-low clock phases, so every stored value is checked against a later, different input. The 20-bit default changes only the vector widths, not the control behaviour.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Strobes handed from a direction's control to its lane
  typedef struct packed {
    logic pass;     // output follows the input
    logic load;     // storage takes the input at this edge
    logic drive;    // side is enabled
    logic testSel;  // output taken from the test word
  } strobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl (
  input  logic              clk,
  input  logic              latchEn,
  input  logic              clkEnN,
  input  logic              dirClk,
  input  logic              oeN,
  input  logic              testMode,
  output xcvr_pkg::strobe_t strb
);
  logic clkPrev;
  logic clkRise;

  // Previous sample of the direction clock; no reset needed, load is gated by rst in the lane
  always_ff @(posedge clk) begin
    clkPrev <= dirClk;
  end

  assign clkRise = dirClk & ~clkPrev;

  always_comb begin
    strb.pass    = latchEn & ~testMode;
    strb.load    = ~testMode & (latchEn | (~clkEnN & clkRise));
    strb.drive   = testMode | ~oeN;
    strb.testSel = testMode;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  xcvr_pkg::strobe_t strb,
  input  logic [W-1:0]      din,
  input  logic [W-1:0]      testVal,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      doe
);
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
    end else if (strb.load) begin
      held <= din;
    end
  end

  always_comb begin
    if (strb.testSel) begin
      dout = testVal;
    end else if (strb.pass) begin
      dout = din;
    end else begin
      dout = held;
    end
    doe = {W{strb.drive}};
  end
endmodule

// File: rtl/xcvr_bidir.sv
module xcvr_bidir #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic         oeAbN,
  input  logic         leAb,
  input  logic         clkEnAbN,
  input  logic         clkAb,
  input  logic         oeBaN,
  input  logic         leBa,
  input  logic         clkEnBaN,
  input  logic         clkBa,
  input  logic         testMode,
  input  logic [W-1:0] testDriveA,
  input  logic [W-1:0] testDriveB,
  output logic [W-1:0] bOut,
  output logic [W-1:0] bOe,
  output logic [W-1:0] aOut,
  output logic [W-1:0] aOe
);
  localparam int NDIR = 2;  // index 0: A to B, index 1: B to A

  logic [NDIR-1:0] leV, clkEnNV, dirClkV, oeNV;
  logic [W-1:0]    dinV   [NDIR];
  logic [W-1:0]    testV  [NDIR];
  logic [W-1:0]    doutV  [NDIR];
  logic [W-1:0]    doeV   [NDIR];

  assign leV     = {leBa, leAb};
  assign clkEnNV = {clkEnBaN, clkEnAbN};
  assign dirClkV = {clkBa, clkAb};
  assign oeNV    = {oeBaN, oeAbN};
  assign dinV[0]  = aIn;
  assign dinV[1]  = bIn;
  assign testV[0] = testDriveB;
  assign testV[1] = testDriveA;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_pkg::strobe_t strb;

    xcvr_ctrl ctrl_i (
      .clk      (clk),
      .latchEn  (leV[d]),
      .clkEnN   (clkEnNV[d]),
      .dirClk   (dirClkV[d]),
      .oeN      (oeNV[d]),
      .testMode (testMode),
      .strb     (strb)
    );

    xcvr_lane #(.W(W)) lane_i (
      .clk     (clk),
      .rst     (rst),
      .strb    (strb),
      .din     (dinV[d]),
      .testVal (testV[d]),
      .dout    (doutV[d]),
      .doe     (doeV[d])
    );
  end

  assign bOut = doutV[0];
  assign bOe  = doeV[0];
  assign aOut = doutV[1];
  assign aOe  = doeV[1];
endmodule

// File: rtl/xcvr_bidir_chk.sv
module xcvr_bidir_chk #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] aIn,
  input logic [W-1:0] bIn,
  input logic         oeAbN,
  input logic         leAb,
  input logic         clkEnAbN,
  input logic         clkAb,
  input logic         oeBaN,
  input logic         leBa,
  input logic         clkEnBaN,
  input logic         clkBa,
  input logic         testMode,
  input logic [W-1:0] testDriveA,
  input logic [W-1:0] testDriveB,
  input logic [W-1:0] bOut,
  input logic [W-1:0] bOe,
  input logic [W-1:0] aOut,
  input logic [W-1:0] aOe
);
  logic prevAb, prevBa;
  always_ff @(posedge clk) begin
    prevAb <= clkAb;
    prevBa <= clkBa;
  end

  assert_transparent_R1: assert property (@(posedge clk) disable iff (rst)
    (leAb && !testMode) |-> bOut == aIn);

  assert_retain_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && leAb && !testMode) && !leAb && !testMode) |-> bOut == $past(aIn));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && !leAb && clkEnAbN && !testMode) && !leAb && !testMode) |-> $stable(bOut));

  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && !leAb && !clkEnAbN && !testMode && clkAb && !prevAb) && !leAb && !testMode)
      |-> bOut == $past(aIn));

  assert_norise_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && !leAb && !testMode && !(clkAb && !prevAb)) && !leAb && !testMode)
      |-> $stable(bOut));

  assert_enable_R6: assert property (@(posedge clk) disable iff (rst)
    !testMode |-> (bOe == (oeAbN ? '0 : {W{1'b1}})) && (aOe == (oeBaN ? '0 : {W{1'b1}})));

  assert_ba_transparent_R7: assert property (@(posedge clk) disable iff (rst)
    (leBa && !testMode) |-> aOut == bIn);

  assert_ba_capture_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && !leBa && !clkEnBaN && !testMode && clkBa && !prevBa) && !leBa && !testMode)
      |-> aOut == $past(bIn));

  assert_test_override_R8: assert property (@(posedge clk) disable iff (rst)
    testMode |-> (bOut == testDriveB) && (aOut == testDriveA) && (&bOe) && (&aOe));

  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !leAb && !leBa && !testMode) |-> (bOut == '0) && (aOut == '0));
endmodule

bind xcvr_bidir xcvr_bidir_chk #(.W(W)) chk_i (.*);

// File: tb/xcvr_bidir_tb.sv
module xcvr_bidir_tb_top;
  localparam int W = 4;
  localparam int NV = 1 << W;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] aIn = '0, bIn = '0, testDriveA = '0, testDriveB = '0;
  logic oeAbN = 1'b1, leAb = 1'b0, clkEnAbN = 1'b1, clkAb = 1'b0;
  logic oeBaN = 1'b1, leBa = 1'b0, clkEnBaN = 1'b1, clkBa = 1'b0;
  logic testMode = 1'b0;
  logic [W-1:0] bOut, bOe, aOut, aOe;

  int checks = 0;
  int bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  xcvr_bidir #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .aIn(aIn), .bIn(bIn),
    .oeAbN(oeAbN), .leAb(leAb), .clkEnAbN(clkEnAbN), .clkAb(clkAb),
    .oeBaN(oeBaN), .leBa(leBa), .clkEnBaN(clkEnBaN), .clkBa(clkBa),
    .testMode(testMode), .testDriveA(testDriveA), .testDriveB(testDriveB),
    .bOut(bOut), .bOe(bOe), .aOut(aOut), .aOe(aOe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Advance to the next falling edge, one system edge later
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] keep;
    // R9: reset clears storage
    aIn = 4'h7; bIn = 4'h9;
    repeat (3) tick();
    #1;
    chk("R9 bOut after reset", bOut, '0);
    chk("R9 aOut after reset", aOut, '0);
    chk("R6 bOe disabled", bOe, '0);
    chk("R6 aOe disabled", aOe, '0);
    rst = 1'b0;
    tick(); #1;
    chk("R9 bOut cleared", bOut, '0);

    // R6: enables
    oeAbN = 1'b0; oeBaN = 1'b0; #1;
    chk("R6 bOe enabled", bOe, ONES);
    chk("R6 aOe enabled", aOe, ONES);

    // R1: transparent sweep A to B
    @(negedge clk); leAb = 1'b1;
    for (int v = 0; v < NV; v++) begin
      aIn = W'(v); #1;
      chk("R1 transparent", bOut, W'(v));
      tick();
    end

    // R2: retain on latch-enable fall
    for (int v = 3; v < NV; v += 5) begin
      leAb = 1'b1; aIn = W'(v);
      tick();
      leAb = 1'b0; aIn = ~W'(v); #1;
      chk("R2 retain", bOut, W'(v));
      tick();
    end

    // R4 / R5: clocked capture
    clkEnAbN = 1'b0; clkAb = 1'b0;
    tick();
    for (int v = 1; v < NV; v += 3) begin
      aIn = W'(v); clkAb = 1'b1;
      tick(); #1;
      chk("R4 capture", bOut, W'(v));
      aIn = ~W'(v); clkAb = 1'b0;
      tick(); #1;
      chk("R5 falling edge", bOut, W'(v));
      aIn = W'(v) ^ 4'h5;
      tick(); #1;
      chk("R5 static low", bOut, W'(v));
    end
    aIn = 4'h3; clkAb = 1'b1;
    tick(); #1;
    chk("R4 capture 3", bOut, 4'h3);
    aIn = 4'h9;
    tick(); tick(); #1;
    chk("R5 static high", bOut, 4'h3);

    // R3: clock enable high holds through clock toggles
    clkEnAbN = 1'b1;
    for (int k = 0; k < 6; k++) begin
      clkAb = ~clkAb; aIn = W'(k + 8);
      tick(); #1;
      chk("R3 hold", bOut, 4'h3);
    end

    // R7: B to A path
    leBa = 1'b1;
    for (int v = 0; v < NV; v++) begin
      bIn = W'(v); #1;
      chk("R7 transparent", aOut, W'(v));
      tick();
    end
    leBa = 1'b0; bIn = 4'hC; #1;
    chk("R7 retain", aOut, 4'hF);
    clkEnBaN = 1'b0; clkBa = 1'b0; bIn = 4'h6;
    tick();
    clkBa = 1'b1;
    tick(); #1;
    chk("R7 capture", aOut, 4'h6);
    bIn = 4'h1;
    tick(); #1;
    chk("R7 static high", aOut, 4'h6);
    clkEnBaN = 1'b1; clkBa = 1'b0;
    tick();
    clkBa = 1'b1;
    tick(); #1;
    chk("R7 hold", aOut, 4'h6);
    oeBaN = 1'b1; #1;
    chk("R7 aOe off", aOe, '0);

    // R8: test override; storage untouched
    keep = 4'h3;
    testMode = 1'b1; testDriveA = 4'h5; testDriveB = 4'hA;
    oeAbN = 1'b1; leAb = 1'b1; leBa = 1'b1; aIn = 4'hF; bIn = 4'hE;
    clkEnAbN = 1'b0; clkAb = 1'b0; #1;
    chk("R8 bOut test", bOut, 4'hA);
    chk("R8 aOut test", aOut, 4'h5);
    chk("R8 bOe test", bOe, ONES);
    chk("R8 aOe test", aOe, ONES);
    tick();
    clkAb = 1'b1;
    tick(); tick();
    testMode = 1'b0; leAb = 1'b0; leBa = 1'b0; clkAb = 1'b1; #1;
    chk("R8 B storage kept", bOut, keep);
    chk("R8 A storage kept", aOut, 4'h6);
    chk("R6 bOe after test", bOe, '0);

    // R9: reset again clears both
    rst = 1'b1;
    tick();
    rst = 1'b0;
    tick(); #1;
    chk("R9 bOut re-reset", bOut, '0);
    chk("R9 aOut re-reset", aOut, '0);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule